// File: doc/BRIEF.md
# Boot-Up Delay Timer

This block keeps system monitoring switched off after power-up until a programmed hold-off time has passed. Counting starts only when two enables are both high: a hardware enable that arrives as an already-qualified digital level, and a software enable bit. The length of the hold-off is chosen by a 4-bit code from a fixed, non-linear table of sixteen times, from 25 µs up to 1.6 s. When the time has run out, the block raises a monitor-enable output.

The clock frequency is a parameter given in kHz. Each time in the table is turned into a cycle count at elaboration, and the counter width is sized to hold the longest count. The block samples the code once, when counting starts. If either enable drops, the block goes back to idle and clears its count. The next start then needs the full delay again. The interface is made of plain control and status pins. No data stream crosses it, so there is no valid/ready handshake and no back-pressure.

Top module: `boot_delay_timer`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released with the enables low, `mon_en` and `busy` are both 0. A reset applied during a count clears both.
- R2: The block starts a count only at an edge where `hw_en` and `sw_en` are both 1. While only one of them is high, `busy` and `mon_en` stay 0.
- R3: Let the starting edge be the first edge that samples both enables high. `busy` is 1 from that edge until `mon_en` goes to 1, which happens on exactly the N-th clock edge after it. N = ceil(T_us * CLK_KHZ / 1000), with a minimum of 1.
- R4: Codes 0 to 7 (binary 0000 to 0111) select T = 25, 500, 1000, 2000, 3000, 4000, 6000 and 8000 µs, in that order.
- R5: Codes 8 to 15 (binary 1000 to 1111) select T = 10000, 12000, 25000, 100000, 200000, 400000, 800000 and 1600000 µs, in that order.
- R6: If either enable goes low during a count, `busy` and `mon_en` are 0 at the next edge. A later restart again takes the full N edges.
- R7: If either enable goes low after completion, `mon_en` is 0 at the next edge. A later restart takes the full N edges.
- R8: `dly_code` is sampled only at the starting edge. Changing it during a count does not move the edge at which `mon_en` rises.
- R9: While both enables stay high after completion, `mon_en` stays 1 and `busy` stays 0. `busy` and `mon_en` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_en | input | 1 | Qualified hardware enable level |
| sw_en | input | 1 | Software enable bit |
| dly_code | input | 4 | Delay selection code |
| mon_en | output | 1 | Monitor enable, registered |
| busy | output | 1 | High while the delay is counting |

## Verification
The bench walks all sixteen codes, each started from idle, and measures the exact edge at which `mon_en` rises. This catches any wrong table entry, wrong rounding, or off-by-one in the counter. Single-enable patterns (hardware only, software only) show that counting is gated by the AND of the two enables and not by either one alone. Drops during a count and after completion, each followed by a restart, show that the count clears rather than resuming. A code changed in the middle of a count shows that the code is latched at the starting edge and is not read continuously.

// File: rtl/bootdly_pkg.sv
package bootdly_pkg;
  localparam int unsigned NUM_CODES = 16;
  localparam int unsigned CODE_W    = $clog2(NUM_CODES);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bd_state_e;

  // Hold-off time in microseconds for each code (non-linear ladder).
  function automatic longint unsigned code_us(input int unsigned c);
    longint unsigned t;
    case (c)
      0:       t = 64'd25;
      1:       t = 64'd500;
      2:       t = 64'd1000;
      3:       t = 64'd2000;
      4:       t = 64'd3000;
      5:       t = 64'd4000;
      6:       t = 64'd6000;
      7:       t = 64'd8000;
      8:       t = 64'd10000;
      9:       t = 64'd12000;
      10:      t = 64'd25000;
      11:      t = 64'd100000;
      12:      t = 64'd200000;
      13:      t = 64'd400000;
      14:      t = 64'd800000;
      default: t = 64'd1600000;
    endcase
    return t;
  endfunction

  // Cycles for a code at a clock of khz kHz, rounded up, never below one.
  function automatic longint unsigned code_cycles(input int unsigned c,
                                                  input int unsigned khz);
    longint unsigned v;
    v = (code_us(c) * longint'(khz) + 64'd999) / 64'd1000;
    if (v == 64'd0) v = 64'd1;
    return v;
  endfunction
endpackage

// File: rtl/bootdly_gate.sv
module bootdly_gate (
  input  logic hw_en,
  input  logic sw_en,
  output logic go
);
  assign go = hw_en & sw_en;
endmodule

// File: rtl/bootdly_lut.sv
module bootdly_lut #(
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned CNT_W   = 28
) (
  input  logic [bootdly_pkg::CODE_W-1:0] code,
  output logic [CNT_W-1:0]               reload
);
  localparam int unsigned N = bootdly_pkg::NUM_CODES;

  logic [CNT_W-1:0] tbl [N];

  // One reload constant per code: terminal count is zero, so store N-1.
  for (genvar i = 0; i < N; i++) begin : g_ent
    localparam longint unsigned CYC = bootdly_pkg::code_cycles(i, CLK_KHZ);
    assign tbl[i] = CNT_W'(CYC - 64'd1);
  end

  assign reload = tbl[code];
endmodule

// File: rtl/bootdly_counter.sv
module bootdly_counter #(
  parameter int unsigned CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] reload,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (clr)                 cnt_q <= '0;
    else if (load)                cnt_q <= reload;
    else if (dec && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> zero);

  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !clr && zero) |=> zero);
endmodule

// File: rtl/bootdly_ctrl.sv
module bootdly_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic zero,
  output logic load,
  output logic dec,
  output logic clr,
  output logic busy,
  output logic mon_en
);
  import bootdly_pkg::*;

  bd_state_e state_q, state_d;
  logic      mon_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (go) state_d = ST_RUN;
      ST_RUN:  if (!go) state_d = ST_IDLE;
               else if (zero) state_d = ST_DONE;
      ST_DONE: if (!go) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mon_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mon_q   <= (state_d == ST_DONE);
    end
  end

  assign load   = (state_q == ST_IDLE) && go;
  assign dec    = (state_q == ST_RUN) && go;
  assign clr    = !go;
  assign busy   = (state_q == ST_RUN);
  assign mon_en = mon_q;

  // R9
  busy_mon_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && mon_en));

  // R2
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy && !mon_en) |=> busy);
endmodule

// File: rtl/boot_delay_timer.sv
module boot_delay_timer #(
  parameter int unsigned CLK_KHZ = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_en,
  input  logic       sw_en,
  input  logic [3:0] dly_code,
  output logic       mon_en,
  output logic       busy
);
  localparam longint unsigned MAX_CYC =
    bootdly_pkg::code_cycles(bootdly_pkg::NUM_CODES - 1, CLK_KHZ);
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

  logic             go, load, dec, clr, zero;
  logic [CNT_W-1:0] reload;

  bootdly_gate u_gate (.hw_en(hw_en), .sw_en(sw_en), .go(go));

  bootdly_lut #(.CLK_KHZ(CLK_KHZ), .CNT_W(CNT_W)) u_lut (
    .code(dly_code), .reload(reload));

  bootdly_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .dec(dec),
    .reload(reload), .zero(zero));

  bootdly_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .zero(zero), .load(load),
    .dec(dec), .clr(clr), .busy(busy), .mon_en(mon_en));

  // R6
  drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_en && sw_en) |=> (!mon_en && !busy));

  // R2
  mon_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mon_en |-> $past(hw_en && sw_en));

  // R9
  mon_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && hw_en && sw_en) |=> mon_en);
endmodule

// File: tb/boot_delay_timer_tb.sv
module boot_delay_timer_tb;
  localparam int unsigned KHZ = 20;
  localparam int unsigned VEC_US [16] = '{25, 500, 1000, 2000, 3000, 4000,
    6000, 8000, 10000, 12000, 25000, 100000, 200000, 400000, 800000, 1600000};

  logic clk = 1'b0, rst_n = 1'b0, hw_en = 1'b0, sw_en = 1'b0;
  logic [3:0] dly_code = 4'd0;
  logic mon_en, busy;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  boot_delay_timer #(.CLK_KHZ(KHZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
    .dly_code(dly_code), .mon_en(mon_en), .busy(busy));

  function automatic int exp_n(input int unsigned us);
    int v = int'((longint'(us) * KHZ + 999) / 1000);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Start from idle with both enables, expect mon_en at exactly n edges.
  task automatic run_delay(input int code, input int n, input string req,
                           input int chg_at, input int new_code);
    int bad = 0;
    dly_code = 4'(code);
    hw_en = 1'b1; sw_en = 1'b1;
    @(negedge clk);
    check(busy && !mon_en, req, "busy after start edge", int'(busy), 1);
    for (int k = 1; k < n; k++) begin
      if (k == chg_at) dly_code = 4'(new_code);
      @(negedge clk);
      if (mon_en || !busy) bad++;
    end
    check(bad == 0, req, "early mon_en or busy gap", bad, 0);
    @(negedge clk);
    check(mon_en && !busy, req, "mon_en at N-th edge", int'(mon_en), 1);
  endtask

  task automatic drop_both();
    hw_en = 1'b0; sw_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!mon_en && !busy, "R1", "during reset", int'(mon_en | busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mon_en && !busy, "R1", "after release", int'(mon_en | busy), 0);

    // R3 R4 R5: walk every code of the table
    for (int c = 0; c < 16; c++) begin
      run_delay(c, exp_n(VEC_US[c]), (c < 8) ? "R4" : "R5", -1, 0);
      drop_both();
      check(!mon_en && !busy, "R7", "idle after drop", int'(mon_en), 0);
    end

    // R2: one enable alone never starts the count
    hw_en = 1'b1; sw_en = 1'b0;
    repeat (5) @(negedge clk);
    check(!busy && !mon_en, "R2", "hw_en alone", int'(busy), 0);
    hw_en = 1'b0; sw_en = 1'b1;
    repeat (5) @(negedge clk);
    check(!busy && !mon_en, "R2", "sw_en alone", int'(busy), 0);
    drop_both();

    // R6: drop during count, then full delay on restart
    dly_code = 4'd3; hw_en = 1'b1; sw_en = 1'b1;
    repeat (10) @(negedge clk);
    check(busy, "R6", "counting before drop", int'(busy), 1);
    sw_en = 1'b0;
    @(negedge clk);
    check(!busy && !mon_en, "R6", "cleared after drop", int'(busy), 0);
    run_delay(3, exp_n(VEC_US[3]), "R6", -1, 0);

    // R9: hold after completion
    repeat (10) @(negedge clk);
    check(mon_en && !busy, "R9", "mon_en held", int'(mon_en), 1);

    // R7: drop after completion, then full restart
    hw_en = 1'b0;
    @(negedge clk);
    check(!mon_en && !busy, "R7", "mon_en off after drop", int'(mon_en), 0);
    run_delay(4, exp_n(VEC_US[4]), "R7", -1, 0);
    drop_both();

    // R8: code changes mid-count are ignored
    run_delay(2, exp_n(VEC_US[2]), "R8", 5, 15);
    drop_both();
    run_delay(1, exp_n(VEC_US[1]), "R8", 3, 0);
    drop_both();

    // R1: reset in the middle of a count
    dly_code = 4'd5; hw_en = 1'b1; sw_en = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!mon_en && !busy, "R1", "reset mid-count", int'(busy), 0);
    drop_both();
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule